// File: doc/BRIEF.md
# FIFO Start Threshold Gate

This block decides the cycle in which a pending transfer may begin on the bus. It looks at FIFO occupancy. A write is held until the transmit FIFO holds enough words. A read is held until the receive FIFO has enough free slots. The gate applies only when a transfer opens with a START or a RESTART. A continuation word passes straight through.

A high-data-rate transfer can open with a RESTART that finds too little data or space. In that case the block does not stall the bus inside that mode. It raises a one-cycle request for an exit pattern, then keeps the transfer waiting until the threshold is met, so the transfer opens with a fresh start. If a transfer is shorter than its threshold, its length becomes the threshold, so a short transfer never deadlocks. The `go` output is registered and falls once the sequencer accepts the transfer.

Top module: `start_gate`

## Requirements
- R1: A write (`req_read`=0) is allowed to go only when `tx_fill` >= the effective transmit threshold.
- R2: A read (`req_read`=1) is allowed to go only when `rx_free` >= the effective receive threshold. The transmit fill has no effect on a read.
- R3: With `req_bnd`=2'b00 (continuation), `go` rises regardless of FIFO levels and thresholds.
- R4: With `req_bnd`=2'b01 (START), 2'b10 (RESTART) or 2'b11 (treated as START), `go` stays low for as long as the threshold is unmet.
- R5: A gated RESTART with `req_hdr`=1 and an unmet threshold pulses `exit_req` high for exactly one cycle. The pulse comes once per wait episode. An episode ends when `req_valid` drops or when `go` is accepted.
- R6: A START, or a RESTART with `req_hdr`=0, never raises `exit_req`. It only waits.
- R7: The effective threshold is the smaller of the programmed threshold and `req_len`. A zero length therefore never waits.
- R8: `go` is registered. It appears on the clock edge after the inputs satisfy the gate, and it is low on the cycle after an edge where `go` and `accept` are both high.
- R9: During and right after reset, `go` and `exit_req` are low.
- R10: `go` and `exit_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A transfer is pending at the gate |
| req_read | input | 1 | 1 = read, 0 = write |
| req_bnd | input | 2 | 00 continuation, 01 START, 10 RESTART, 11 as START |
| req_hdr | input | 1 | Transfer runs in high-data-rate double-rate mode |
| req_len | input | LEN_W | Total words in the transfer |
| tx_fill | input | CNT_W | Words held in the transmit FIFO |
| rx_free | input | CNT_W | Free slots in the receive FIFO |
| tx_thld | input | CNT_W | Transmit start threshold |
| rx_thld | input | CNT_W | Receive start threshold |
| accept | input | 1 | Sequencer takes the transfer while `go` is high |
| go | output | 1 | Transfer may begin (registered) |
| exit_req | output | 1 | One-cycle request to emit the exit pattern |

## Verification
Two events can land on the same clock edge. One is accepting a granted transfer; the other is the gate finding the threshold still met. The bench holds `req_valid` high and the FIFO level above threshold while pulsing `accept` for a single cycle. It expects `go` to drop for one cycle and then return. A second episode checks that a RESTART exit request fires once. After the request, the bench holds the wait for several cycles and confirms that no repeat pulse and no grant appear. It then raises the fill level and expects the grant to follow one edge later.

// File: rtl/start_gate.sv
module start_gate #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [1:0]       req_bnd,
  input  logic             req_hdr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic [CNT_W-1:0] rx_free,
  input  logic [CNT_W-1:0] tx_thld,
  input  logic [CNT_W-1:0] rx_thld,
  input  logic             accept,
  output logic             go,
  output logic             exit_req
);

  localparam logic [1:0] BND_CONT    = 2'b00;
  localparam logic [1:0] BND_RESTART = 2'b10;
  localparam int         CMP_W       = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [CMP_W-1:0] level, thr, len_ext, eff;
  logic             gated, met, ok, exit_now, taken;
  logic             go_q, exit_q, exited_q;

  assign level    = req_read ? CMP_W'(rx_free) : CMP_W'(tx_fill);
  assign thr      = req_read ? CMP_W'(rx_thld) : CMP_W'(tx_thld);
  assign len_ext  = CMP_W'(req_len);
  assign eff      = (thr < len_ext) ? thr : len_ext;
  assign met      = level >= eff;
  assign gated    = req_bnd != BND_CONT;
  assign ok       = !gated || met;
  assign taken    = go_q && accept;
  assign exit_now = req_valid && req_hdr && (req_bnd == BND_RESTART)
                    && !ok && !exited_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      exit_q   <= 1'b0;
      exited_q <= 1'b0;
    end else begin
      go_q     <= req_valid && ok && !taken;
      exit_q   <= exit_now;
      exited_q <= req_valid && (exited_q || exit_now) && !taken;
    end
  end

  assign go       = go_q;
  assign exit_req = exit_q;

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && exit_req));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !exit_req);

  a_r8_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (go && accept) |=> !go);

  a_r4_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> $past(req_valid));

  a_r6_exit_only_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_req) |-> ($past(req_bnd) == BND_RESTART && $past(req_hdr)));

endmodule

// File: tb/start_gate_bench.sv
module start_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0, req_hdr = 1'b0, accept = 1'b0;
  logic [1:0]  req_bnd = 2'b01;
  logic [15:0] req_len = 16'd0, tx_fill = 16'd0, rx_free = 16'd0;
  logic [15:0] tx_thld = 16'd0, rx_thld = 16'd0;
  logic        go, exit_req;
  int          total = 0, bad = 0, cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  start_gate u_start_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_bnd(req_bnd), .req_hdr(req_hdr), .req_len(req_len),
    .tx_fill(tx_fill), .rx_free(rx_free), .tx_thld(tx_thld), .rx_thld(rx_thld),
    .accept(accept), .go(go), .exit_req(exit_req)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  bnd;
    logic        hdr;
    logic [15:0] len, fill, free, tthr, rthr;
    logic        e_go, e_ex;
    logic [7:0]  tag;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{1'b0, 2'b01, 1'b0, 16'd100, 16'd8,  16'd0,  16'd8, 16'd4,  1'b1, 1'b0, 8'd1}, // R1 met
    '{1'b0, 2'b01, 1'b0, 16'd100, 16'd7,  16'd0,  16'd8, 16'd4,  1'b0, 1'b0, 8'd4}, // R4 unmet
    '{1'b1, 2'b01, 1'b0, 16'd100, 16'd0,  16'd4,  16'd8, 16'd4,  1'b1, 1'b0, 8'd2}, // R2 met
    '{1'b1, 2'b01, 1'b0, 16'd100, 16'd50, 16'd3,  16'd8, 16'd4,  1'b0, 1'b0, 8'd2}, // R2 fill ignored
    '{1'b0, 2'b00, 1'b0, 16'd100, 16'd0,  16'd0,  16'd8, 16'd4,  1'b1, 1'b0, 8'd3}, // R3 write cont
    '{1'b1, 2'b00, 1'b1, 16'd100, 16'd0,  16'd0,  16'd8, 16'd4,  1'b1, 1'b0, 8'd3}, // R3 read cont
    '{1'b0, 2'b10, 1'b1, 16'd100, 16'd2,  16'd0,  16'd8, 16'd4,  1'b0, 1'b1, 8'd5}, // R5 write
    '{1'b1, 2'b10, 1'b1, 16'd100, 16'd0,  16'd1,  16'd8, 16'd4,  1'b0, 1'b1, 8'd5}, // R5 read
    '{1'b0, 2'b10, 1'b0, 16'd100, 16'd2,  16'd0,  16'd8, 16'd4,  1'b0, 1'b0, 8'd6}, // R6 non-hdr restart
    '{1'b0, 2'b01, 1'b1, 16'd100, 16'd2,  16'd0,  16'd8, 16'd4,  1'b0, 1'b0, 8'd6}, // R6 hdr start
    '{1'b0, 2'b01, 1'b0, 16'd3,   16'd3,  16'd0,  16'd8, 16'd4,  1'b1, 1'b0, 8'd7}, // R7 short write
    '{1'b1, 2'b11, 1'b0, 16'd2,   16'd0,  16'd2,  16'd8, 16'd10, 1'b1, 1'b0, 8'd7}, // R7 short read
    '{1'b0, 2'b01, 1'b0, 16'd3,   16'd2,  16'd0,  16'd8, 16'd4,  1'b0, 1'b0, 8'd7}, // R7 short unmet
    '{1'b0, 2'b10, 1'b1, 16'd0,   16'd0,  16'd0,  16'd8, 16'd4,  1'b1, 1'b0, 8'd7}  // R7 zero length
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    chk("R9", go, 1'b0, "go in reset");
    chk("R9", exit_req, 1'b0, "exit in reset");
    step();
    rst_n = 1'b1;
    step();
    chk("R9", go, 1'b0, "go after reset");
    chk("R9", exit_req, 1'b0, "exit after reset");

    foreach (TBL[i]) begin
      req_valid = 1'b0;
      step();
      req_read = TBL[i].rd;  req_bnd = TBL[i].bnd; req_hdr = TBL[i].hdr;
      req_len  = TBL[i].len; tx_fill = TBL[i].fill; rx_free = TBL[i].free;
      tx_thld  = TBL[i].tthr; rx_thld = TBL[i].rthr;
      req_valid = 1'b1;
      step();
      chk($sformatf("R%0d", TBL[i].tag), go, TBL[i].e_go, $sformatf("go vec %0d", i));
      chk($sformatf("R%0d", TBL[i].tag), exit_req, TBL[i].e_ex, $sformatf("exit vec %0d", i));
    end

    // R5 episode: one pulse, then a silent wait, then the grant when met
    req_valid = 1'b0; step();
    req_read = 1'b0; req_bnd = 2'b10; req_hdr = 1'b1; req_len = 16'd100;
    tx_thld = 16'd8; tx_fill = 16'd1; req_valid = 1'b1;
    step();
    chk("R5", exit_req, 1'b1, "first exit pulse");
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5", exit_req, 1'b0, "no repeat pulse");
      chk("R4", go, 1'b0, "held while unmet");
    end
    tx_fill = 16'd8;
    chk("R8", go, 1'b0, "go not combinational");
    step();
    chk("R8", go, 1'b1, "go one edge after met");
    chk("R10", exit_req, 1'b0, "no exit with go");

    // R8: accept coincides with a still-met threshold
    accept = 1'b1;
    step();
    accept = 1'b0;
    chk("R8", go, 1'b0, "go drops after accept");
    step();
    chk("R8", go, 1'b1, "go returns for next transfer");

    // R5: a new episode after valid drops pulses again
    req_valid = 1'b0; tx_fill = 16'd0; step();
    req_valid = 1'b1;
    step();
    chk("R5", exit_req, 1'b1, "pulse in new episode");
    step();
    chk("R5", exit_req, 1'b0, "single pulse in new episode");

    // R1: equality at the boundary through a write START
    req_bnd = 2'b01; req_hdr = 1'b0; tx_fill = 16'd8;
    step();
    chk("R1", go, 1'b1, "fill equals threshold");

    req_valid = 1'b0;
    step();
    chk("R8", go, 1'b0, "go clears without request");
    finish_run();
  end
endmodule